// File: doc/BRIEF.md
# Serial Cell-Size Configuration Loader

This block captures, once after reset, the settings that a cell-based demultiplexing buffer needs. The settings are a 7-bit cell-size code and a 3-bit port-group identifier. In wide-bus operation they arrive as a ten-bit serial frame on three slow pins: a load enable, a shift clock and a data line. The shift clock is not used as a clock. All three pins are synchronised into the main clock domain, and a rising edge of the synchronised shift clock moves one bit in. In narrow-bus operation the serial path is disabled. The same ten bits are then taken in parallel from the data pin and nine spare strap pins.

A completed load is decoded into a cell length in bytes, where a zero code stands for 128 bytes. The block then raises either a valid flag or an illegal-size flag.

The controller has six states:
- ST_IDLE: waiting for the load enable.
- ST_SHIFT: collecting bits.
- ST_CHECK: one cycle that decodes the finished frame.
- ST_DONE and ST_ERR: terminal results.
- ST_STRAP: parallel mode.

The transitions are:
- START: ST_IDLE to ST_SHIFT when the enable is seen.
- ABORT: ST_SHIFT to ST_IDLE when the enable drops early.
- TENTH: ST_SHIFT to ST_CHECK on the tenth bit.
- ACCEPT: ST_CHECK to ST_DONE.
- REJECT: ST_CHECK to ST_ERR.
- NARROW: any state to ST_STRAP while the bus-width select is high.
- WIDEN: ST_STRAP to ST_IDLE when the select falls.

Top module: `cfgl_loader`

## Requirements
- R1: After reset, cfg_valid, size_err, size_code, dev_id and cell_bytes are all 0.
- R2: With bus_narrow low and ld_en high, each rising edge of ld_sck shifts in one ld_sdi bit. The first seven bits form size_code, with the first bit as bit 0. The next three bits form dev_id, with the first of them as bit 0.
- R3: cfg_valid stays low until the tenth bit has been captured; after nine bits it is still low.
- R4: A size_code of 0 gives cell_bytes = 128 with cfg_valid high.
- R5: A size_code of 16 to 127 gives cell_bytes equal to the code with cfg_valid high.
- R6: A size_code of 1 to 15 gives size_err high, cfg_valid low and cell_bytes equal to the code.
- R7: If ld_en falls before ten bits are captured, the partial frame is discarded and cfg_valid stays low. A later load starts again from the first bit.
- R8: Once a serial load has ended in valid or in error, further serial activity changes no output until reset.
- R9: While bus_narrow is high, serial loading is ignored. size_code is {strap_bits[5:0], ld_sdi}, dev_id is strap_bits[8:6], and cfg_valid and size_err follow the rules of R4 to R6 within a few cycles.
- R10: When bus_narrow falls, cfg_valid and size_err go low, and the block waits for a serial load.
- R11: cfg_valid and size_err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset |
| bus_narrow | input | 1 | Bus-width select; high selects parallel strapping |
| ld_en | input | 1 | Serial load enable (asynchronous) |
| ld_sck | input | 1 | Serial shift clock (asynchronous, sampled) |
| ld_sdi | input | 1 | Serial data; bit 0 of the size in parallel mode |
| strap_bits | input | 9 | Spare data pins used as parallel strap |
| size_code | output | 7 | Captured cell-size code |
| cell_bytes | output | 8 | Decoded cell length in bytes |
| dev_id | output | 3 | Captured port-group identifier |
| cfg_valid | output | 1 | Configuration captured and legal |
| size_err | output | 1 | Captured size is 1 to 15 bytes |

## Verification
The assertions check four things on every cycle:
- The valid and error flags never overlap.
- A valid configuration always decodes to a length of 16 to 128 bytes, and a zero code always maps to 128.
- An error always carries a length below 16.
- A serial result stays frozen while the bus stays wide.

Bit ordering, the tenth-bit timing of the valid flag, aborts by an early enable drop, and the mapping of strap pins can only be shown by the bench's serial and parallel scenarios. The bench compares these against frames it computes itself.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CHECK,
        ST_DONE,
        ST_ERR,
        ST_STRAP
    } cfgl_state_e;

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift #(
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame,
    output logic               last
);

    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            frame <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            frame <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
            // first bit received ends up at index 0
            frame <= {bit_in, frame[FRAME_W-1:1]};
        end
    end

    assign last = (cnt_q == LAST_IDX);

endmodule

// File: rtl/cfgl_decode.sv
module cfgl_decode #(
    parameter int SIZE_W    = 7,
    parameter int MIN_BYTES = 16
) (
    input  logic [SIZE_W-1:0] code,
    output logic [SIZE_W:0]   bytes,
    output logic              legal
);

    localparam logic [SIZE_W:0] FULL  = (SIZE_W+1)'(1) << SIZE_W;
    localparam logic [SIZE_W:0] MIN_B = (SIZE_W+1)'(MIN_BYTES);

    always_comb begin
        if (code == '0) bytes = FULL;
        else            bytes = {1'b0, code};
        legal = (bytes >= MIN_B);
    end

endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader #(
    parameter int SIZE_W      = 7,
    parameter int ID_W        = 3,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_BYTES   = 16,
    localparam int FRAME_W    = SIZE_W + ID_W,
    localparam int STRAP_W    = FRAME_W - 1,
    localparam int BYTES_W    = SIZE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_narrow,
    input  logic               ld_en,
    input  logic               ld_sck,
    input  logic               ld_sdi,
    input  logic [STRAP_W-1:0] strap_bits,
    output logic [SIZE_W-1:0]  size_code,
    output logic [BYTES_W-1:0] cell_bytes,
    output logic [ID_W-1:0]    dev_id,
    output logic               cfg_valid,
    output logic               size_err
);

    import cfgl_pkg::*;

    cfgl_state_e state_q, state_d;

    // synchronised serial pins: {enable, clock, data}
    logic [2:0] ser_s;
    logic       en_s, sck_s, sdi_s, sck_d, sck_rise;

    cfgl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ld_en, ld_sck, ld_sdi}),
        .q     (ser_s)
    );

    assign en_s  = ser_s[2];
    assign sck_s = ser_s[1];
    assign sdi_s = ser_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_d;

    logic [STRAP_W-1:0] strap_s;

    cfgl_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_sync_strap (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (strap_bits),
        .q     (strap_s)
    );

    logic [FRAME_W-1:0] par_frame;
    assign par_frame = {strap_s, sdi_s};

    // serial frame collection
    logic               sh_clr, sh_step, sh_last;
    logic [FRAME_W-1:0] ser_frame;

    assign sh_clr  = (state_q != ST_SHIFT);
    assign sh_step = (state_q == ST_SHIFT) && en_s && sck_rise;

    cfgl_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sh_clr),
        .step   (sh_step),
        .bit_in (sdi_s),
        .frame  (ser_frame),
        .last   (sh_last)
    );

    // decode of whichever frame is being committed
    logic [FRAME_W-1:0] sel_frame;
    logic [BYTES_W-1:0] dec_bytes;
    logic               dec_legal;

    assign sel_frame = (state_q == ST_STRAP) ? par_frame : ser_frame;

    cfgl_decode #(.SIZE_W(SIZE_W), .MIN_BYTES(MIN_BYTES)) u_decode (
        .code  (sel_frame[SIZE_W-1:0]),
        .bytes (dec_bytes),
        .legal (dec_legal)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (bus_narrow) begin
            state_d = ST_STRAP;                               // NARROW
        end else begin
            unique case (state_q)
                ST_IDLE:  if (en_s) state_d = ST_SHIFT;       // START
                ST_SHIFT: begin
                    if (!en_s)                  state_d = ST_IDLE;  // ABORT
                    else if (sh_step && sh_last) state_d = ST_CHECK; // TENTH
                end
                ST_CHECK: state_d = dec_legal ? ST_DONE : ST_ERR;   // ACCEPT / REJECT
                ST_DONE:  state_d = ST_DONE;
                ST_ERR:   state_d = ST_ERR;
                ST_STRAP: state_d = ST_IDLE;                  // WIDEN
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_code  <= '0;
            dev_id     <= '0;
            cell_bytes <= '0;
            cfg_valid  <= 1'b0;
            size_err   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CHECK, ST_STRAP: begin
                    size_code  <= sel_frame[SIZE_W-1:0];
                    dev_id     <= sel_frame[FRAME_W-1:SIZE_W];
                    cell_bytes <= dec_bytes;
                    cfg_valid  <= dec_legal;
                    size_err   <= ~dec_legal;
                end
                ST_IDLE, ST_SHIFT: begin
                    cfg_valid <= 1'b0;
                    size_err  <= 1'b0;
                end
                ST_DONE, ST_ERR: begin
                    cfg_valid <= cfg_valid;
                    size_err  <= size_err;
                end
                default: begin
                    cfg_valid <= 1'b0;
                    size_err  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cfgl_loader_chk.sv
module cfgl_loader_chk #(
    parameter int SIZE_W = 7,
    parameter int ID_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_narrow,
    input logic [SIZE_W-1:0] size_code,
    input logic [SIZE_W:0]   cell_bytes,
    input logic [ID_W-1:0]   dev_id,
    input logic              cfg_valid,
    input logic              size_err
);

    localparam logic [SIZE_W:0] FULL = (SIZE_W+1)'(1) << SIZE_W;

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && size_err));

    a_r5_valid_range: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cell_bytes >= (SIZE_W+1)'(16) && cell_bytes <= FULL));

    a_r4_zero_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && size_code == '0) |-> (cell_bytes == FULL));

    a_r6_err_small: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> (cell_bytes < (SIZE_W+1)'(16) && cell_bytes != '0));

    a_r8_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !bus_narrow && !$past(bus_narrow) && !$past(bus_narrow, 2))
        |=> (cfg_valid && $stable(size_code) && $stable(dev_id)));

endmodule

bind cfgl_loader cfgl_loader_chk #(.SIZE_W(SIZE_W), .ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_narrow (bus_narrow),
    .size_code  (size_code),
    .cell_bytes (cell_bytes),
    .dev_id     (dev_id),
    .cfg_valid  (cfg_valid),
    .size_err   (size_err)
);

// File: tb/test_cfgl_loader.sv
module test_cfgl_loader;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_narrow = 1'b0;
    logic       ld_en = 1'b0;
    logic       ld_sck = 1'b0;
    logic       ld_sdi = 1'b0;
    logic [8:0] strap_bits = '0;
    logic [6:0] size_code;
    logic [7:0] cell_bytes;
    logic [2:0] dev_id;
    logic       cfg_valid;
    logic       size_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgl_loader i_cfgl_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_narrow (bus_narrow),
        .ld_en      (ld_en),
        .ld_sck     (ld_sck),
        .ld_sdi     (ld_sdi),
        .strap_bits (strap_bits),
        .size_code  (size_code),
        .cell_bytes (cell_bytes),
        .dev_id     (dev_id),
        .cfg_valid  (cfg_valid),
        .size_err   (size_err)
    );

    function automatic logic [7:0] exp_bytes(input logic [6:0] c);
        return (c == 7'd0) ? 8'd128 : {1'b0, c};
    endfunction

    function automatic logic exp_legal(input logic [6:0] c);
        return (c == 7'd0) || (c >= 7'd16);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_narrow = 1'b0; ld_en = 1'b0;
        ld_sck = 1'b0; ld_sdi = 1'b0; strap_bits = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic send_bit(input logic b);
        ld_sdi = b;
        wait_clk(HALF);
        ld_sck = 1'b1;
        wait_clk(HALF);
        ld_sck = 1'b0;
    endtask

    // sends the first nbits of the frame {id, code}, LSB first
    task automatic send_frame(input logic [6:0] c, input logic [2:0] id, input int nbits);
        logic [9:0] f;
        f = {id, c};
        ld_en = 1'b1;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) send_bit(f[i]);
        wait_clk(8);
    endtask

    task automatic check_out(input string req, input logic ev, input logic ee,
                             input logic [6:0] ec, input logic [2:0] ei,
                             input logic [7:0] eb);
        n_tests++;
        if (cfg_valid !== ev || size_err !== ee || size_code !== ec ||
            dev_id !== ei || cell_bytes !== eb) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b err=%0b code=%0d id=%0d bytes=%0d, expected valid=%0b err=%0b code=%0d id=%0d bytes=%0d",
                     req, cfg_valid, size_err, size_code, dev_id, cell_bytes,
                     ev, ee, ec, ei, eb);
        end
    endtask

    task automatic check_flag(input string req, input logic ev, input logic ee);
        n_tests++;
        if (cfg_valid !== ev || size_err !== ee) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b err=%0b, expected valid=%0b err=%0b",
                     req, cfg_valid, size_err, ev, ee);
        end
    endtask

    task automatic serial_case(input string req, input logic [6:0] c, input logic [2:0] id);
        do_reset();
        send_frame(c, id, 10);
        check_out(req, exp_legal(c), !exp_legal(c), c, id, exp_bytes(c));
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4711);

        // R1 reset state
        do_reset();
        check_out("R1 reset", 1'b0, 1'b0, 7'd0, 3'd0, 8'd0);

        // R3: nine bits are not enough, the tenth completes it
        do_reset();
        send_frame(7'd0, 3'd5, 9);
        check_flag("R3 after nine bits", 1'b0, 1'b0);
        send_bit(1'b1);
        wait_clk(8);
        check_out("R3 R4 tenth bit, zero code", 1'b1, 1'b0, 7'd0, 3'd5, 8'd128);

        // size boundaries
        serial_case("R5 code 16", 7'd16, 3'd0);
        serial_case("R5 code 127", 7'd127, 3'd7);
        serial_case("R6 code 15", 7'd15, 3'd2);
        serial_case("R6 code 1", 7'd1, 3'd6);

        // R7 abort then reload
        do_reset();
        send_frame(7'h7F, 3'd7, 4);
        ld_en = 1'b0;
        wait_clk(8);
        check_flag("R7 after abort", 1'b0, 1'b0);
        send_frame(7'h2A, 3'd3, 10);
        check_out("R7 reload from first bit", 1'b1, 1'b0, 7'h2A, 3'd3, 8'h2A);

        // R8 further serial activity ignored after valid
        ld_en = 1'b0;
        wait_clk(8);
        send_frame(7'h55, 3'd1, 10);
        check_out("R8 ignored after valid", 1'b1, 1'b0, 7'h2A, 3'd3, 8'h2A);

        // R8 ignored after error
        serial_case("R6 code 9", 7'd9, 3'd4);
        ld_en = 1'b0;
        wait_clk(8);
        send_frame(7'd40, 3'd2, 10);
        check_out("R8 ignored after error", 1'b0, 1'b1, 7'd9, 3'd4, 8'd9);

        // R9 parallel strapping, R10 leaving it
        for (int k = 0; k < 6; k++) begin
            logic [9:0] f;
            do_reset();
            if (k == 0)      f = {3'd6, 7'd0};
            else if (k == 1) f = {3'd1, 7'd5};
            else             f = 10'($urandom);
            bus_narrow = 1'b1;
            strap_bits = f[9:1];
            ld_sdi     = f[0];
            wait_clk(8);
            send_frame(~f[6:0], ~f[9:7], 10);
            ld_sdi = f[0];
            wait_clk(8);
            check_out("R9 strap", exp_legal(f[6:0]), !exp_legal(f[6:0]),
                      f[6:0], f[9:7], exp_bytes(f[6:0]));
            ld_en = 1'b0;
            bus_narrow = 1'b0;
            wait_clk(8);
            check_flag("R10 leave narrow", 1'b0, 1'b0);
        end

        // R2 random serial frames, R11 checked through the flags
        for (int t = 0; t < 16; t++) begin
            logic [6:0] c;
            logic [2:0] id;
            c  = 7'($urandom);
            id = 3'($urandom);
            serial_case("R2 R11 random serial", c, id);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule